// File: doc/BRIEF.md
# Four-Phase Raised-Cosine Interpolator with Quarter-Rate Upmix

This block takes complex baseband samples at chip rate and turns each one into four real output samples, already placed on a digital carrier. A 40-tap raised-cosine pulse-shaping filter with 30% excess bandwidth interpolates by four. It is split into four polyphase branches, so the block runs on the slow chip clock and still produces the fast output stream: four samples per clock, earliest first, on one parallel bus. In a typical chip the core clock is 64 MHz and the output behaves as a 256 MS/s stream on a 64 MHz carrier.

The carrier sits at one quarter of the output sample rate. Its cosine and sine take only the values 0 and ±1, so the mix reduces to choosing between the I and Q paths and fixing a sign for each lane. Each lane therefore filters only the component it uses, so there is one branch per lane and not one per component. The full-precision lane sums are rounded and clamped to the output width. The interpolation taps come from a fixed internal table.

Top module: `rc_polyphase_upmix`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and every lane of samp_o is 0 until the first output sample is produced.
- R2: valid_o is high in exactly the cycles that follow a cycle with valid_i high by three clock edges, for any pattern of gaps in valid_i.
- R3: In a cycle with valid_o low, samp_o keeps the value it had in the previous cycle.
- R4: Tap n (0..39) has the value h[n] = h[39-n]. For n = 20..39 the values in order are 511, 407, 239, 68, -51, -95, -76, -25, 20, 39, 31, 10, -8, -15, -11, -3, 2, 3, 2, 0. Lane p (0..3) of the output for input sample m uses the filtered sum F_p(x) = sum over j = 0..9 of h[4j+p]·x[m-j].
- R5: The fs/4 mix uses cos = 1,0,-1,0 and sin = 0,1,0,-1 for lanes 0..3, and each lane is I·cos − Q·sin. Lane 0 is +F_0(I), lane 1 is −F_1(Q), lane 2 is −F_2(I), and lane 3 is +F_3(Q).
- R6: Each mixed lane sum s is rounded to floor((s + 256) / 512) and clamped to the signed OUT_W range. Lane p occupies samp_o bits [p·OUT_W +: OUT_W], and lane 0 is the earliest output in time.
- R7: i_i and q_i are ignored in cycles with valid_i low. The sample history advances only on valid cycles.
- R8: Once ten consecutive valid input samples with I = Q = 0 have been accepted, the output produced for the last of them has all four lanes equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| i_i | input | IN_W | In-phase sample, signed |
| q_i | input | IN_W | Quadrature sample, signed |
| valid_o | output | 1 | Output group strobe |
| samp_o | output | 4·OUT_W | Four signed real samples, lane 0 earliest |

## Verification
The assertions assume that the inputs only change between clock edges. They also assume that valid_i stays low while reset is asserted, so that the latency shadow in the checker starts empty together with the design pipeline. The bench drives all inputs on the falling edge and holds valid_i at 0 through reset. During invalid cycles it places unrelated values on i_i and q_i, so the ignore rule is exercised while every property stays within its assumptions. The zero-flush property counts the run of zero samples itself, so it only fires when the bench has actually delivered ten zeros in a row.

// File: rtl/rc_upmix_pkg.sv
package rc_upmix_pkg;
  localparam int unsigned NUM_PHASES     = 4;
  localparam int unsigned TAPS_TOTAL     = 40;
  localparam int unsigned TAPS_PER_PHASE = TAPS_TOTAL / NUM_PHASES;
  localparam int unsigned HALF_TAPS      = TAPS_TOTAL / 2;
  localparam int unsigned COEF_W         = 10;

  typedef enum logic [1:0] {
    MIX_POS_I,
    MIX_NEG_Q,
    MIX_NEG_I,
    MIX_POS_Q
  } mix_sel_e;

  // fs/4 carrier: lane p of every group sits at carrier phase p
  function automatic mix_sel_e mix_for_phase(input int unsigned p);
    case (p % 4)
      0:       return MIX_POS_I;
      1:       return MIX_NEG_Q;
      2:       return MIX_NEG_I;
      default: return MIX_POS_Q;
    endcase
  endfunction

  // symmetric pulse: only the right half is stored, folded about the centre
  function automatic logic signed [COEF_W-1:0] rc_coef(input int unsigned idx);
    int unsigned k;
    k = (idx < HALF_TAPS) ? (HALF_TAPS - 1 - idx) : (idx - HALF_TAPS);
    case (k)
      0:       return 10'sd511;
      1:       return 10'sd407;
      2:       return 10'sd239;
      3:       return 10'sd68;
      4:       return -10'sd51;
      5:       return -10'sd95;
      6:       return -10'sd76;
      7:       return -10'sd25;
      8:       return 10'sd20;
      9:       return 10'sd39;
      10:      return 10'sd31;
      11:      return 10'sd10;
      12:      return -10'sd8;
      13:      return -10'sd15;
      14:      return -10'sd11;
      15:      return -10'sd3;
      16:      return 10'sd2;
      17:      return 10'sd3;
      18:      return 10'sd2;
      default: return 10'sd0;
    endcase
  endfunction
endpackage

// File: rtl/rc_upmix_hist.sv
module rc_upmix_hist #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned DEPTH = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        shift_i,
  input  logic [IN_W-1:0]             i_i,
  input  logic [IN_W-1:0]             q_i,
  output logic [DEPTH-1:0][IN_W-1:0]  i_hist_o,
  output logic [DEPTH-1:0][IN_W-1:0]  q_hist_o
);
  logic [DEPTH-1:0][IN_W-1:0] i_hist_q, q_hist_q;

  // entry 0 is the newest sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_hist_q <= '0;
      q_hist_q <= '0;
    end else if (shift_i) begin
      i_hist_q <= {i_hist_q[DEPTH-2:0], i_i};
      q_hist_q <= {q_hist_q[DEPTH-2:0], q_i};
    end
  end

  assign i_hist_o = i_hist_q;
  assign q_hist_o = q_hist_q;
endmodule

// File: rtl/rc_upmix_subfilt.sv
module rc_upmix_subfilt
  import rc_upmix_pkg::*;
#(
  parameter int unsigned IN_W   = 8,
  parameter int unsigned ACC_W  = 23,
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned PHASE  = 0,
  parameter bit          NEGATE = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [DEPTH-1:0][IN_W-1:0]  x_hist_i,
  output logic signed [ACC_W-1:0]     acc_o
);
  logic signed [ACC_W-1:0] sum_d, acc_q;

  always_comb begin
    logic signed [ACC_W-1:0] xe, ce;
    sum_d = '0;
    for (int j = 0; j < int'(DEPTH); j++) begin
      xe    = ACC_W'($signed(x_hist_i[j]));
      ce    = ACC_W'(rc_coef(PHASE + NUM_PHASES * unsigned'(j)));
      sum_d = sum_d + xe * ce;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= NEGATE ? -sum_d : sum_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/rc_upmix_rndsat.sv
module rc_upmix_rndsat #(
  parameter int unsigned ACC_W = 23,
  parameter int unsigned SHIFT = 9,
  parameter int unsigned OUT_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic [OUT_W-1:0]         y_o
);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] MAX_V    = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V    = -MAX_V - ACC_W'(1);

  logic signed [ACC_W-1:0] biased, shifted;
  logic [OUT_W-1:0]        y_d, y_q;

  always_comb begin
    biased  = acc_i + HALF_LSB;
    shifted = biased >>> SHIFT;
    if (shifted > MAX_V)      y_d = MAX_V[OUT_W-1:0];
    else if (shifted < MIN_V) y_d = MIN_V[OUT_W-1:0];
    else                      y_d = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_q <= '0;
    else if (en_i) y_q <= y_d;
  end

  assign y_o = y_q;
endmodule

// File: rtl/rc_polyphase_upmix.sv
module rc_polyphase_upmix
  import rc_upmix_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned SHIFT = COEF_W - 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic signed [IN_W-1:0]        i_i,
  input  logic signed [IN_W-1:0]        q_i,
  output logic                          valid_o,
  output logic [NUM_PHASES*OUT_W-1:0]   samp_o
);
  // one guard bit beyond the tap-sum growth covers the lane negation
  localparam int unsigned ACC_W = IN_W + COEF_W + $clog2(TAPS_PER_PHASE) + 1;

  logic [TAPS_PER_PHASE-1:0][IN_W-1:0] i_hist, q_hist;
  logic v1_q, v2_q, v3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= valid_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  rc_upmix_hist #(
    .IN_W  (IN_W),
    .DEPTH (TAPS_PER_PHASE)
  ) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (valid_i),
    .i_i      (i_i),
    .q_i      (q_i),
    .i_hist_o (i_hist),
    .q_hist_o (q_hist)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_lane
    localparam mix_sel_e LANE_MIX = mix_for_phase(p);
    localparam bit USE_Q = (LANE_MIX == MIX_NEG_Q) || (LANE_MIX == MIX_POS_Q);
    localparam bit NEG   = (LANE_MIX == MIX_NEG_Q) || (LANE_MIX == MIX_NEG_I);

    logic signed [ACC_W-1:0] lane_acc;

    rc_upmix_subfilt #(
      .IN_W   (IN_W),
      .ACC_W  (ACC_W),
      .DEPTH  (TAPS_PER_PHASE),
      .PHASE  (p),
      .NEGATE (NEG)
    ) u_sub (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (v1_q),
      .x_hist_i (USE_Q ? q_hist : i_hist),
      .acc_o    (lane_acc)
    );

    rc_upmix_rndsat #(
      .ACC_W (ACC_W),
      .SHIFT (SHIFT),
      .OUT_W (OUT_W)
    ) u_rnd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v2_q),
      .acc_i  (lane_acc),
      .y_o    (samp_o[p*OUT_W +: OUT_W])
    );
  end

  assign valid_o = v3_q;
endmodule

// File: rtl/rc_polyphase_upmix_chk.sv
module rc_polyphase_upmix_chk
  import rc_upmix_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         valid_i,
  input logic [IN_W-1:0]              i_i,
  input logic [IN_W-1:0]              q_i,
  input logic                         valid_o,
  input logic [NUM_PHASES*OUT_W-1:0]  samp_o
);
  logic [2:0] vpipe, zpipe;
  logic [7:0] zrun;
  logic       seen_v;
  logic       zero_in;

  assign zero_in = valid_i && (i_i == '0) && (q_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpipe  <= '0;
      zpipe  <= '0;
      zrun   <= '0;
      seen_v <= 1'b0;
    end else begin
      vpipe <= {vpipe[1:0], valid_i};
      zpipe <= {zpipe[1:0], zero_in && (zrun >= 8'(TAPS_PER_PHASE - 1))};
      if (valid_i)
        zrun <= !zero_in ? 8'd0 : (zrun >= 8'(TAPS_PER_PHASE) ? zrun : zrun + 8'd1);
      if (valid_o) seen_v <= 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_v && !valid_o) |-> (samp_o == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vpipe[2]);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(samp_o));

  // R8
  zero_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zpipe[2]) |-> (samp_o == '0));
endmodule

bind rc_polyphase_upmix rc_polyphase_upmix_chk #(
  .IN_W  (IN_W),
  .OUT_W (OUT_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .i_i     (i_i),
  .q_i     (q_i),
  .valid_o (valid_o),
  .samp_o  (samp_o)
);

// File: tb/rc_polyphase_upmix_tb_top.sv
module rc_polyphase_upmix_tb_top;
  localparam int IN_W  = 8;
  localparam int OUT_W = 12;
  localparam int NP    = 4;
  localparam int NT    = 10;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  valid_i = 1'b0;
  logic signed [IN_W-1:0] i_i = '0;
  logic signed [IN_W-1:0] q_i = '0;
  logic                  valid_o;
  logic [NP*OUT_W-1:0]   samp_o;

  always #5 clk = ~clk;

  rc_polyphase_upmix #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .i_i(i_i), .q_i(q_i),
    .valid_o(valid_o), .samp_o(samp_o)
  );

  int    n_vec = 0, n_bad = 0;
  int    hi[NT], hq[NT];
  bit    pv[3];
  int    pe[3][NP];
  string preq[3];
  int    last_out[NP];
  string cur_req = "R4";
  logic [15:0] lfsr = 16'hACE1;

  // R4 tap values, right half
  function automatic int coef(int n);
    int half[20] = '{511, 407, 239, 68, -51, -95, -76, -25, 20, 39,
                     31, 10, -8, -15, -11, -3, 2, 3, 2, 0};
    return (n < 20) ? half[19 - n] : half[n - 20];
  endfunction

  function automatic int model_lane(int p);
    int acc = 0;
    int r;
    for (int j = 0; j < NT; j++)
      acc += coef(4 * j + p) * (((p % 2) == 0) ? hi[j] : hq[j]);
    if (p == 1 || p == 2) acc = -acc;          // R5 signs
    r = (acc + 256) >>> 9;                     // R6 rounding
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  function automatic int lane(int p);
    return int'($signed(samp_o[p*OUT_W +: OUT_W]));
  endfunction

  task automatic check_cycle();
    n_vec++;
    if (valid_o !== pv[2]) begin
      n_bad++;
      $display("FAIL R2 valid_o: got %0b expected %0b", valid_o, pv[2]);
    end
    for (int p = 0; p < NP; p++) begin
      n_vec++;
      if (pv[2]) begin
        if (lane(p) != pe[2][p]) begin
          n_bad++;
          $display("FAIL %s lane%0d: got %0d expected %0d", preq[2], p, lane(p), pe[2][p]);
        end
      end else if (lane(p) != last_out[p]) begin
        n_bad++;
        $display("FAIL R3 hold lane%0d: got %0d expected %0d", p, lane(p), last_out[p]);
      end
    end
    if (pv[2]) for (int p = 0; p < NP; p++) last_out[p] = pe[2][p];
  endtask

  task automatic step(bit v, int iv, int qv);
    @(negedge clk);
    check_cycle();
    pv[2] = pv[1]; pv[1] = pv[0];
    preq[2] = preq[1]; preq[1] = preq[0];
    for (int p = 0; p < NP; p++) begin
      pe[2][p] = pe[1][p];
      pe[1][p] = pe[0][p];
    end
    pv[0] = v;
    preq[0] = cur_req;
    if (v) begin
      for (int j = NT - 1; j > 0; j--) begin
        hi[j] = hi[j-1];
        hq[j] = hq[j-1];
      end
      hi[0] = iv;
      hq[0] = qv;
      for (int p = 0; p < NP; p++) pe[0][p] = model_lane(p);
    end
    valid_i = v;
    i_i = IN_W'(iv);
    q_i = IN_W'(qv);
  endtask

  function automatic int rnd8();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[7:0]));
  endfunction

  task automatic impulse(int iv, int qv);
    step(1'b1, iv, qv);
    for (int k = 0; k < NT + 2; k++) step(1'b1, 0, 0);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < NT; j++) begin hi[j] = 0; hq[j] = 0; end
    for (int s = 0; s < 3; s++) begin
      pv[s] = 1'b0;
      preq[s] = "R4";
      for (int p = 0; p < NP; p++) pe[s][p] = 0;
    end
    for (int p = 0; p < NP; p++) last_out[p] = 0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      n_vec++;
      if (valid_o !== 1'b0 || samp_o !== '0) begin
        n_bad++;
        $display("FAIL R1 reset: got valid=%0b samp=%0h expected 0/0", valid_o, samp_o);
      end
    end
    rst_ni = 1'b1;
    cur_req = "R1";
    repeat (3) step(1'b0, 0, 0);

    // R4: in-phase impulses expose every tap
    cur_req = "R4";
    impulse(1, 0);
    impulse(100, 0);
    impulse(-128, 0);
    impulse(127, 0);
    // R5: quadrature impulses and mixed
    cur_req = "R5";
    impulse(0, 100);
    impulse(0, -128);
    impulse(55, -77);

    // R6: sweep every in-phase value, paired quadrature
    cur_req = "R6";
    for (int v = -128; v < 128; v++) step(1'b1, v, ((v * 37) % 256 + 256) % 256 - 128);
    for (int k = 0; k < NT; k++) step(1'b1, 127, -128);
    for (int k = 0; k < NT; k++) step(1'b1, -128, 127);

    // R7: sparse valid with junk data on idle cycles; R3 holds checked on gaps
    cur_req = "R7";
    for (int k = 0; k < 600; k++) begin
      int a = rnd8();
      int b = rnd8();
      step(lfsr[11] | lfsr[3], a, b);
    end

    // R8: ten zeros flush the response
    cur_req = "R8";
    for (int k = 0; k < NT + 3; k++) begin
      step(1'b1, 0, 0);
      if (k % 3 == 1) step(1'b0, rnd8(), rnd8());
    end

    cur_req = "R2";
    repeat (5) step(1'b0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule